// File: doc/BRIEF.md
# Bit-Serial Adder with Sequencing Controller

This block forms the sum of two unsigned WIDTH-bit operands using one full-adder cell and one carry flip-flop. It spends one clock per bit position. Both operands sit in registers that shift right, so the adder sees the least significant bit first. Each sum bit enters the top of a result register. After WIDTH shifts the result register holds the whole sum.

A small controller sequences each addition. A start pulse clears the carry and begins the run. A bit counter ends the run after exactly WIDTH shifts. The carry leaving the top bit is captured at that point, and a completion flag is raised and held.

The operand registers rotate rather than drain. A second start without a new load therefore repeats the same addition. Operands are loaded in parallel while no run is in progress.

Top module: `bitser_add`

## Requirements
- R1: After reset, `done`, `sum_out` and `carry_out` are all zero and the block is idle.
- R2: When `start` is sampled high at a clock edge while idle or finished, `done` stays low for the next WIDTH-1 edges and is high after the WIDTH-th edge that follows.
- R3: When `done` is high, `sum_out` equals (A + B) mod 2^WIDTH, where A and B are the unsigned operands last loaded.
- R4: When `done` is high, `carry_out` equals bit WIDTH of the unsigned sum A + B.
- R5: A `start` pulse during a run is ignored: completion time and results are those of the original run.
- R6: Once high, `done` and the results hold until `start` is sampled; the edge that samples `start` drops `done` to zero.
- R7: `load` captures `a_in` and `b_in` when no run is in progress; a `load` during a run has no effect on the operands.
- R8: The carry is cleared at the start of every run, so a run that ended with a carry of 1 does not change the next result.
- R9: The operands are unchanged after a run, so a new `start` without a `load` repeats the same sum and carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Parallel capture of both operands (ignored during a run) |
| a_in | input | WIDTH | First operand, unsigned |
| b_in | input | WIDTH | Second operand, unsigned |
| start | input | 1 | Pulse that begins an addition |
| done | output | 1 | High when a result is ready; held until the next start |
| sum_out | output | WIDTH | Low WIDTH bits of the sum |
| carry_out | output | 1 | Carry out of the top bit position |

## Verification
The tests cover several kinds of operand pair, and each kind exposes a different fault.
- Zero plus zero shows any stuck sum or carry bit.
- One plus one, and 0x7F plus one, send a carry through the low bits and then across the middle of the word.
- 0x80 plus 0x80 produces only a final carry, which checks that the carry is captured on the last bit.
- Complementary patterns such as 0xA5 plus 0x5A, which never carry, catch a swapped sum and carry.
- All-ones plus all-ones generates a carry at every position.
- A following zero-plus-zero run shows whether that carry leaks into the next addition.
- Directed runs with start and load pulses inside a run separate a controller that restarts from one that ignores them.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bsa_state_e;

  // One-bit addition: returns {carry, sum}
  function automatic logic [1:0] fa_cell(input logic x, input logic y, input logic ci);
    logic s;
    logic co;
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
    return {co, s};
  endfunction

endpackage

// File: rtl/bsa_fa.sv
module bsa_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  import bsa_pkg::*;

  logic [1:0] res;

  always_comb begin
    res = fa_cell(x, y, ci);
    s   = res[0];
    co  = res[1];
  end

endmodule

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (ld)    q <= ld_val;
    else if (shift) q <= {ser_in, q[W-1:1]};
  end

endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic run,
  output logic last_bit,
  output logic carry_clr,
  output logic done
);
  import bsa_pkg::*;

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  bsa_state_e     state;
  logic [CW-1:0]  cnt;

  always_comb begin
    run       = (state == ST_RUN);
    done      = (state == ST_DONE);
    carry_clr = start && !run;
    last_bit  = run && (cnt == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (last_bit) state <= ST_DONE;
        end
        default: begin
          if (start) begin
            state <= ST_RUN;
            cnt   <= '0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/bitser_add.sv
module bitser_add #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             start,
  output logic             done,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);

  // Named internal events (also observed by the checker)
  logic run;
  logic last_bit;
  logic carry_clr;
  logic load_ok;
  logic carry_q;
  logic cout_q;
  logic sum_bit;
  logic fa_co;

  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q;
  logic [WIDTH-1:0] r_q;

  assign load_ok = load && !run;

  bsa_ctrl #(.W(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .run       (run),
    .last_bit  (last_bit),
    .carry_clr (carry_clr),
    .done      (done)
  );

  // Operand registers rotate so they survive a run
  bsa_shreg #(.W(WIDTH)) u_areg (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (load_ok),
    .ld_val (a_in),
    .shift  (run),
    .ser_in (a_q[0]),
    .q      (a_q)
  );

  bsa_shreg #(.W(WIDTH)) u_breg (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (load_ok),
    .ld_val (b_in),
    .shift  (run),
    .ser_in (b_q[0]),
    .q      (b_q)
  );

  bsa_shreg #(.W(WIDTH)) u_rreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (carry_clr),
    .ld_val ({WIDTH{1'b0}}),
    .shift  (run),
    .ser_in (sum_bit),
    .q      (r_q)
  );

  bsa_fa u_fa (
    .x  (a_q[0]),
    .y  (b_q[0]),
    .ci (carry_q),
    .s  (sum_bit),
    .co (fa_co)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      cout_q  <= 1'b0;
    end else begin
      if (carry_clr)    carry_q <= 1'b0;
      else if (run)     carry_q <= fa_co;
      if (carry_clr)    cout_q  <= 1'b0;
      else if (last_bit) cout_q <= fa_co;
    end
  end

  assign sum_out   = r_q;
  assign carry_out = cout_q;

endmodule

// File: rtl/bsa_chk.sv
module bsa_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic         run,
  input logic         last_bit,
  input logic         carry_clr,
  input logic         carry_q,
  input logic [W-1:0] sum_out,
  input logic         carry_out
);

  logic [31:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= '0;
    else if (carry_clr) cyc <= '0;
    else if (run)       cyc <= cyc + 1;
  end

  a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |=> done);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cyc == W));

  a_r5_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last_bit) |=> (!done && run));

  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(sum_out) && $stable(carry_out)));

  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && run));

  a_r8_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
    carry_clr |=> (carry_q == 1'b0));

  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && done));

endmodule

bind bitser_add bsa_chk #(.W(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .run       (run),
  .last_bit  (last_bit),
  .carry_clr (carry_clr),
  .carry_q   (carry_q),
  .sum_out   (sum_out),
  .carry_out (carry_out)
);

// File: tb/bitser_add_test.sv
module bitser_add_test;

  localparam int W      = 8;
  localparam int CLK_NS = 10;
  localparam int NVEC   = 9;
  // {a, b}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0000, 16'h0101, 16'h7F01, 16'h8080, 16'hFF01,
    16'hA55A, 16'h1234, 16'hFFFF, 16'h0000
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         start = 1'b0;
  logic         done;
  logic [W-1:0] sum_out;
  logic         carry_out;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit over   = 0;

  bitser_add #(.WIDTH(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .a_in      (a_in),
    .b_in      (b_in),
    .start     (start),
    .done      (done),
    .sum_out   (sum_out),
    .carry_out (carry_out)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !over) begin
      over = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic load_ops(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    load = 1'b1; a_in = a; b_in = b;
    @(negedge clk);
    load = 1'b0;
  endtask

  // Pulse start, then confirm done is low until WIDTH edges after the start edge
  task automatic run_and_wait(input string req);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " done low after start"}, int'(done), 0);
    repeat (W - 1) @(negedge clk);
    chk({req, " R2 done low before last bit"}, int'(done), 0);
    @(negedge clk);
    chk({req, " R2 done high after WIDTH bits"}, int'(done), 1);
  endtask

  task automatic chk_result(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    int total;
    total = int'(a) + int'(b);
    chk({req, " R3 sum"}, int'(sum_out), total % (1 << W));
    chk({req, " R4 carry"}, int'(carry_out), total / (1 << W));
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 done", int'(done), 0);
    chk("R1 sum", int'(sum_out), 0);
    chk("R1 carry", int'(carry_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table of vectors: R2, R3, R4
    for (int i = 0; i < NVEC; i++) begin
      load_ops(VEC[i][15:8], VEC[i][7:0]);
      run_and_wait("vec");
      chk_result("vec", VEC[i][15:8], VEC[i][7:0]);
    end

    // R6: done and results hold without start
    load_ops(8'hC8, 8'h64);
    run_and_wait("R6a");
    repeat (5) @(negedge clk);
    chk("R6 done held", int'(done), 1);
    chk_result("R6 held", 8'hC8, 8'h64);

    // R5 and R7: start and load pulses in mid-run are ignored
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k < W; k++) begin
      if (k == 3) begin
        start = 1'b1; load = 1'b1; a_in = 8'h00; b_in = 8'h00;
      end else begin
        start = 1'b0; load = 1'b0;
      end
      @(negedge clk);
      if (k == W - 1) chk("R5 done low before last bit", int'(done), 0);
    end
    start = 1'b0; load = 1'b0;
    @(negedge clk);
    chk("R5 done on time despite start", int'(done), 1);
    chk_result("R5 R7 mid-run pulses", 8'hC8, 8'h64);

    // R9: restart without load repeats the sum (also shows R7 load ignored); R6 drop
    @(negedge clk);
    run_and_wait("R9 R6 restart");
    chk_result("R9 R7 retained operands", 8'hC8, 8'h64);

    // R8: carry from an all-ones run must not leak into the next
    load_ops(8'hFF, 8'hFF);
    run_and_wait("R8a");
    chk_result("R8 all-ones", 8'hFF, 8'hFF);
    load_ops(8'h00, 8'h00);
    run_and_wait("R8b");
    chk_result("R8 zero after carry", 8'h00, 8'h00);

    // R7: load while finished is accepted
    load_ops(8'h01, 8'hFF);
    run_and_wait("R7 load when done");
    chk_result("R7 load when done", 8'h01, 8'hFF);

    over = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule